// File: doc/BRIEF.md
# Undervoltage Lockout Fault Supervisor

This block watches four digital undervoltage flags beside a three-phase half-bridge gate driver. There is one bootstrap flag per phase and one flag for the shared gate supply. Each raw flag goes through its own deglitch counter, so a brief glitch never reaches the outputs. The filtered flags drive two enable masks that the output stage uses to gate its drivers: one mask for the high-side drivers and one for the low-side drivers. A status vector reports which faults are active.

The two fault types recover in different ways. A bootstrap fault turns off only the high-side enable of its own phase. The fault is latched and is released only when two things are true: the filtered flag has returned to good, and the phase's high-side command then shows a fresh low-to-high transition. A gate-supply fault turns off every enable in every phase. It releases by itself once the filtered supply flag is good again. After reset the block reports a supply fault and keeps every output masked until a filtered good-supply indication arrives.

Top module: `uvlo_supervisor`

## Requirements
- R1: A bootstrap flag held at 1 for BST_DEG_CYC consecutive clock samples latches that phase's fault. The fault appears on the rising edge after the last of those samples: `bst_fault_o[i]` goes to 1 and `hs_en_o[i]` goes to 0.
- R2: A raw flag that stays high for fewer than its deglitch count of consecutive samples changes no output. This holds for both the supply and the bootstrap flags.
- R3: A bootstrap fault on phase i clears only `hs_en_o[i]`. The high-side enables of the other phases and every `ls_en_o` bit keep their values.
- R4: A latched bootstrap fault stays latched after its flag has been filtered back to good. It clears on the clock edge that samples `hs_cmd_i[i]`=1 when the previous sample was 0. On that same edge `hs_en_o[i]` returns to 1, provided the supply is good.
- R5: A rising edge on `hs_cmd_i[i]` does not re-arm phase i if it is sampled while the filtered bootstrap flag is still 1. This includes the deglitch window that follows the raw flag going low. A later edge is needed.
- R6: Once the supply flag has been held at 1 for SUP_DEG_CYC samples, all `hs_en_o` and `ls_en_o` bits go to 0 on the next edge and `sup_fault_o` goes to 1.
- R7: Once the supply flag has been held at 0 for SUP_DEG_CYC samples, `sup_fault_o` goes to 0 and every `ls_en_o` bit goes to 1 on the next edge. No command edge is needed for this. A phase whose bootstrap fault is still latched keeps its `hs_en_o` bit at 0.
- R8: While reset is held, `sup_fault_o`=1, `bst_fault_o`=0, and all enable bits are 0. After reset is released, the supply is treated as faulty until R7's release condition is met.
- R9: The status bits and the enable masks change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bst_uv_raw_i | input | NUM_PH (3) | Raw bootstrap undervoltage flag per phase, 1 = undervoltage |
| sup_uv_raw_i | input | 1 | Raw gate-supply undervoltage flag, 1 = undervoltage |
| hs_cmd_i | input | NUM_PH (3) | High-side command per phase; its rising edges re-arm a phase |
| hs_en_o | output | NUM_PH (3) | High-side enable mask, 1 = driver may switch |
| ls_en_o | output | NUM_PH (3) | Low-side enable mask, 1 = driver may switch |
| bst_fault_o | output | NUM_PH (3) | Latched bootstrap fault per phase |
| sup_fault_o | output | 1 | Filtered gate-supply fault |

## Verification
Suppose a flag is first driven to a new level just after clock edge c. Its filter then flips on edge c+DEG, and the status and masks follow on edge c+DEG+1. A re-arming command edge driven after edge c takes effect on edge c+1. The bench uses these offsets to give every expected item a due cycle. It also places a copy of the previous state one cycle earlier, so the check shows that the change happens on the stated edge and not one edge too early. Items for glitches and for ignored command edges are due several cycles after the stimulus, which is past the point where a wrong response would already be visible.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;
  // Bits needed to count from 0 up to n-1 (at least one bit).
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/uvlo_deglitch.sv
module uvlo_deglitch #(
  parameter int   DEG_CYC = 500,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = uvlo_pkg::cnt_w(DEG_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEG_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  // The filter flips only after DEG_CYC consecutive samples that differ from it.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else if (raw_i != filt_q) begin
      if (cnt_q == LAST) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign filt_o = filt_q;

  // R1
  filt_follows_raw_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> (filt_q == $past(raw_i)));
  // R2
  filt_full_window_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/uvlo_phase_latch.sv
module uvlo_phase_latch (
  input  logic clk,
  input  logic rst,
  input  logic bst_flt_i,
  input  logic sup_flt_i,
  input  logic hs_cmd_i,
  output logic fault_o,
  output logic hs_en_o
);
  logic hs_prev_q;
  logic lat_q;
  logic hs_en_q;
  logic rise;
  logic lat_nxt;

  assign rise    = hs_cmd_i & ~hs_prev_q;
  // While the filtered flag is bad the latch stays set, so a command edge
  // is consumed without effect.
  assign lat_nxt = bst_flt_i | (lat_q & ~rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_prev_q <= 1'b1;
      lat_q     <= 1'b0;
      hs_en_q   <= 1'b0;
    end else begin
      hs_prev_q <= hs_cmd_i;
      lat_q     <= lat_nxt;
      hs_en_q   <= ~lat_nxt & ~sup_flt_i;
    end
  end

  assign fault_o = lat_q;
  assign hs_en_o = hs_en_q;

  // R5
  rearm_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lat_q) |-> ($past(hs_cmd_i) && !$past(hs_prev_q) && !$past(bst_flt_i)));
  // R1
  latch_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    bst_flt_i |=> lat_q);
  // R6
  hs_off_on_supply_chk: assert property (@(posedge clk) disable iff (rst)
    sup_flt_i |=> !hs_en_q);
endmodule

// File: rtl/uvlo_supervisor.sv
module uvlo_supervisor #(
  parameter int NUM_PH      = 3,
  parameter int SUP_DEG_CYC = 500,
  parameter int BST_DEG_CYC = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PH-1:0] bst_uv_raw_i,
  input  logic              sup_uv_raw_i,
  input  logic [NUM_PH-1:0] hs_cmd_i,
  output logic [NUM_PH-1:0] hs_en_o,
  output logic [NUM_PH-1:0] ls_en_o,
  output logic [NUM_PH-1:0] bst_fault_o,
  output logic              sup_fault_o
);
  logic              sup_filt;
  logic [NUM_PH-1:0] bst_filt;
  logic [NUM_PH-1:0] ls_en_q;
  logic              sup_q;

  // Supply filter starts in the faulty state.
  uvlo_deglitch #(.DEG_CYC(SUP_DEG_CYC), .RST_VAL(1'b1)) u_sup_flt (
    .clk(clk), .rst(rst), .raw_i(sup_uv_raw_i), .filt_o(sup_filt));

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    uvlo_deglitch #(.DEG_CYC(BST_DEG_CYC), .RST_VAL(1'b0)) u_bst_flt (
      .clk(clk), .rst(rst), .raw_i(bst_uv_raw_i[p]), .filt_o(bst_filt[p]));

    uvlo_phase_latch u_latch (
      .clk      (clk),
      .rst      (rst),
      .bst_flt_i(bst_filt[p]),
      .sup_flt_i(sup_filt),
      .hs_cmd_i (hs_cmd_i[p]),
      .fault_o  (bst_fault_o[p]),
      .hs_en_o  (hs_en_o[p]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_q   <= 1'b1;
      ls_en_q <= '0;
    end else begin
      sup_q   <= sup_filt;
      ls_en_q <= {NUM_PH{~sup_filt}};
    end
  end

  assign sup_fault_o = sup_q;
  assign ls_en_o     = ls_en_q;

  // R6
  supply_masks_all_chk: assert property (@(posedge clk) disable iff (rst)
    sup_fault_o |-> (hs_en_o == '0 && ls_en_o == '0));
  // R3
  bst_fault_hs_off_chk: assert property (@(posedge clk) disable iff (rst)
    (bst_fault_o & hs_en_o) == '0);
endmodule

// File: tb/uvlo_supervisor_bench.sv
module uvlo_supervisor_bench;
  localparam int NPH = 3;
  localparam int SD  = 12;
  localparam int BD  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPH-1:0] bst_raw = '0;
  logic           sup_raw = 1'b0;
  logic [NPH-1:0] hs_cmd  = '0;
  logic [NPH-1:0] hs_en, ls_en, bst_flt;
  logic           sup_flt;

  always #10 clk = ~clk;

  uvlo_supervisor #(.NUM_PH(NPH), .SUP_DEG_CYC(SD), .BST_DEG_CYC(BD)) u_uvlo_supervisor (
    .clk(clk), .rst(rst), .bst_uv_raw_i(bst_raw), .sup_uv_raw_i(sup_raw),
    .hs_cmd_i(hs_cmd), .hs_en_o(hs_en), .ls_en_o(ls_en),
    .bst_fault_o(bst_flt), .sup_fault_o(sup_flt));

  typedef struct {
    int             due;
    logic [NPH-1:0] hs;
    logic [NPH-1:0] ls;
    logic [NPH-1:0] bst;
    logic           sup;
    string          tag;
  } exp_t;

  exp_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [NPH-1:0] e_hs = '0, e_ls = '0, e_bst = '0;
  logic           e_sup = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int due, input string tag);
    exp_t it;
    it.due = due; it.hs = e_hs; it.ls = e_ls; it.bst = e_bst; it.sup = e_sup; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) step();
  endtask

  // Monitor: compare each due item against the ports at the falling edge.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t it;
      it = sbq.pop_front();
      checks++;
      if (it.due != cyc || hs_en != it.hs || ls_en != it.ls ||
          bst_flt != it.bst || sup_flt != it.sup) begin
        bad++;
        $display("FAIL %s cyc=%0d due=%0d: hs=%b ls=%b bst=%b sup=%b expected hs=%b ls=%b bst=%b sup=%b",
                 it.tag, cyc, it.due, hs_en, ls_en, bst_flt, sup_flt, it.hs, it.ls, it.bst, it.sup);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c;
    step(); step(); step();
    // R8: state under reset
    push(cyc, "R8 reset state");
    step();
    rst = 1'b0; c = cyc;
    push(c + SD, "R8 still masked before supply filter");
    e_hs = '1; e_ls = '1; e_sup = 1'b0;
    push(c + SD + 1, "R8 R7 release after good supply");
    wait_until(c + SD + 2);

    // R2: supply glitch one sample short
    c = cyc; sup_raw = 1'b1;
    repeat (SD - 1) step();
    sup_raw = 1'b0;
    push(c + SD + 3, "R2 supply glitch ignored");
    wait_until(c + SD + 4);

    // R2: bootstrap glitch one sample short on phase 1
    c = cyc; bst_raw[1] = 1'b1;
    repeat (BD - 1) step();
    bst_raw[1] = 1'b0;
    push(c + BD + 3, "R2 bootstrap glitch ignored");
    wait_until(c + BD + 4);

    // R1 R3 R9: bootstrap fault on phase 0
    c = cyc; bst_raw[0] = 1'b1;
    push(c + BD, "R1 no fault before full window");
    e_hs = 3'b110; e_bst = 3'b001;
    push(c + BD + 1, "R1 R3 R9 phase0 fault");
    wait_until(c + BD + 2);

    // R5: edge while the fault is present
    c = cyc; hs_cmd[0] = 1'b1;
    push(c + 2, "R5 edge during fault ignored");
    step(); step(); hs_cmd[0] = 1'b0; step();

    // R5: edge inside the clear deglitch window
    c = cyc; bst_raw[0] = 1'b0;
    step(); step(); hs_cmd[0] = 1'b1;
    step(); step(); hs_cmd[0] = 1'b0;
    push(c + 5, "R5 edge during clear window ignored");
    wait_until(c + BD + 3);
    // R4: condition gone but no edge yet
    push(cyc + 1, "R4 still latched without edge");
    step(); step();
    c = cyc; hs_cmd[0] = 1'b1;
    push(c, "R4 latched before edge");
    e_hs = '1; e_bst = '0;
    push(c + 1, "R4 re-armed by edge");
    step(); step(); hs_cmd[0] = 1'b0; step();

    // R3: fault on phase 2
    c = cyc; bst_raw[2] = 1'b1;
    push(c + BD, "R3 phase2 before window");
    e_hs = 3'b011; e_bst = 3'b100;
    push(c + BD + 1, "R3 phase2 fault only");
    wait_until(c + BD + 2);
    bst_raw[2] = 1'b0;
    repeat (BD + 2) step();

    // R6: supply fault masks everything
    c = cyc; sup_raw = 1'b1;
    push(c + SD, "R6 before supply window");
    e_hs = '0; e_ls = '0; e_sup = 1'b1;
    push(c + SD + 1, "R6 R9 supply fault masks all");
    wait_until(c + SD + 2);

    // R7: automatic supply recovery, phase2 stays latched
    c = cyc; sup_raw = 1'b0;
    push(c + SD, "R7 before good window");
    e_hs = 3'b011; e_ls = '1; e_sup = 1'b0;
    push(c + SD + 1, "R7 auto recovery");
    wait_until(c + SD + 2);

    // R4: re-arm phase 2
    c = cyc; hs_cmd[2] = 1'b1;
    e_hs = '1; e_bst = '0;
    push(c + 1, "R4 phase2 re-armed");
    repeat (4) step();

    if (sbq.size() != 0) begin
      checks++; bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", sbq.size());
    end
    finish_run();
  end
endmodule